// File: doc/BRIEF.md
# Word-Serial Flash/Memory Block Mover

This block copies a contiguous, word-aligned run of 32-bit words between a flash address window and system memory. Software sets a flash start address, a memory start address and a length through a small register port. It optionally enables a completion interrupt, then sets the start bit together with a direction bit. The engine fetches one word from the source port, stores it to the destination port, and repeats until the run is complete. It then raises a done flag and, if enabled, the interrupt line.

Both sides are plain valid/ready request ports. A read request is answered by a response strobe carrying the data. A write request completes on its handshake. Software acknowledges completion by writing zero to the status register and then zero to the control register. Clearing the start bit while a run is active stops the engine once the word it is currently moving has been stored. Register reads are combinational from the address.

Top module: `flash_dma_engine`

## Requirements
- R1: Register map. Offset 0x08 is interrupt enable (bit 3, read/write) and done (bit 11). Offset 0x80 is control: bit 0 is start and bit 1 is direction. Offset 0x84 is the flash base, 0x88 the memory base and 0x8C the length. Unused bits read as zero.
- R2: With direction 0, the words at increasing flash addresses from the flash base are copied to increasing memory addresses from the memory base. The number of words is (length field / 4) + 1.
- R3: With direction 1, the copy runs from memory to flash with the same word count and address order.
- R4: A length field of zero moves exactly one word.
- R5: Writes to either base register clear address bits 1:0. Writes to the length register keep only bits 24:2, so writing all ones reads back 0x01FFFFFC. Every request address is word aligned.
- R6: The interrupt output is high exactly while the enable bit and the done bit are both set.
- R7: A write to offset 0x08 with bit 11 clear clears done. A transfer launches only on a control write that takes the start bit from 0 to 1 while the engine is idle. Rewriting start=1 over start=1 moves nothing.
- R8: While a run is active, reads of 0x8C return the bytes still to move in the minus-four encoding. After k of N words have been stored, this is (N-1-k)*4.
- R9: Clearing the start bit mid-run lets the word being moved finish, moves no further word, and leaves done clear.
- R10: Each word is fully read before it is written. The two ports never request in the same cycle, and a request holds its address and kind until accepted.
- R11: Writes to the base and length registers are ignored while a run is active. The active run is unaffected.
- R12: After reset all registers read zero, the interrupt is low and neither port requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| irq | output | 1 | Completion interrupt |
| fl_valid | output | 1 | Flash request valid |
| fl_we | output | 1 | Flash request is a write |
| fl_addr | output | AW | Flash request byte address |
| fl_wdata | output | 32 | Flash write data |
| fl_ready | input | 1 | Flash request accepted |
| fl_rvalid | input | 1 | Flash read data valid |
| fl_rdata | input | 32 | Flash read data |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory request byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory request accepted |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
The assertions check the following on every cycle:
- the two ports are never active together;
- a stalled request holds its address and kind;
- every request address is word aligned;
- the interrupt rises only after a destination write handshake or a register write.

The following can only be shown by the bench's scenarios:
- that the right words land at the right addresses in both directions;
- the exact word count for a given length field;
- the remaining-length readback mid-run;
- the stopping point of an abort;
- the 0-to-1 launch rule;
- that register writes are ignored while a run is active.

// File: rtl/flash_dma_engine.sv
module flash_dma_engine #(
  parameter int AW     = 32,
  parameter int LEN_HI = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic          irq,
  output logic          fl_valid,
  output logic          fl_we,
  output logic [AW-1:0] fl_addr,
  output logic [31:0]   fl_wdata,
  input  logic          fl_ready,
  input  logic          fl_rvalid,
  input  logic [31:0]   fl_rdata,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata
);
  localparam int CW = LEN_HI - 1;
  localparam logic [7:0] OFF_STAT = 8'h08;
  localparam logic [7:0] OFF_CTRL = 8'h80;
  localparam logic [7:0] OFF_FBAS = 8'h84;
  localparam logic [7:0] OFF_MBAS = 8'h88;
  localparam logic [7:0] OFF_LEN  = 8'h8C;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WAIT, S_WR} state_t;

  state_t         state;
  logic           start_q, dir_q, run_dir, ie_q, done_q;
  logic [AW-1:0]  fbase_q, mbase_q, src_ptr, dst_ptr;
  logic [CW-1:0]  len_q, rem_q;
  logic [31:0]    buf_q;

  logic busy, wr_stat, wr_ctrl, launch;
  logic src_ready, src_rvalid, dst_ready;
  logic [31:0] src_rdata;
  logic [CW-1:0] len_view;

  assign busy    = (state != S_IDLE);
  assign wr_stat = cfg_we && (cfg_addr == OFF_STAT);
  assign wr_ctrl = cfg_we && (cfg_addr == OFF_CTRL);
  assign launch  = wr_ctrl && cfg_wdata[0] && !start_q && !busy;

  assign src_ready  = run_dir ? mem_ready  : fl_ready;
  assign src_rvalid = run_dir ? mem_rvalid : fl_rvalid;
  assign src_rdata  = run_dir ? mem_rdata  : fl_rdata;
  assign dst_ready  = run_dir ? fl_ready   : mem_ready;

  assign fl_valid  = ((state == S_RD) && !run_dir) || ((state == S_WR) && run_dir);
  assign mem_valid = ((state == S_RD) && run_dir) || ((state == S_WR) && !run_dir);
  assign fl_we     = (state == S_WR);
  assign mem_we    = (state == S_WR);
  assign fl_addr   = run_dir ? dst_ptr : src_ptr;
  assign mem_addr  = run_dir ? src_ptr : dst_ptr;
  assign fl_wdata  = buf_q;
  assign mem_wdata = buf_q;

  assign irq = ie_q && done_q;

  assign len_view = busy ? rem_q : len_q;

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      OFF_STAT: begin
        cfg_rdata[3]  = ie_q;
        cfg_rdata[11] = done_q;
      end
      OFF_CTRL: cfg_rdata[1:0] = {dir_q, start_q};
      OFF_FBAS: cfg_rdata = 32'(fbase_q);
      OFF_MBAS: cfg_rdata = 32'(mbase_q);
      OFF_LEN:  cfg_rdata[LEN_HI:2] = len_view;
      default:  cfg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
      ie_q    <= 1'b0;
      fbase_q <= '0;
      mbase_q <= '0;
      len_q   <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        OFF_STAT: ie_q <= cfg_wdata[3];
        OFF_CTRL: begin
          start_q <= cfg_wdata[0];
          dir_q   <= cfg_wdata[1];
        end
        OFF_FBAS: if (!busy) fbase_q <= {cfg_wdata[AW-1:2], 2'b00};
        OFF_MBAS: if (!busy) mbase_q <= {cfg_wdata[AW-1:2], 2'b00};
        OFF_LEN:  if (!busy) len_q   <= cfg_wdata[LEN_HI:2];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      run_dir <= 1'b0;
      done_q  <= 1'b0;
      src_ptr <= '0;
      dst_ptr <= '0;
      rem_q   <= '0;
      buf_q   <= '0;
    end else begin
      if (wr_stat && !cfg_wdata[11]) done_q <= 1'b0;
      case (state)
        S_IDLE: if (launch) begin
          run_dir <= cfg_wdata[1];
          src_ptr <= cfg_wdata[1] ? mbase_q : fbase_q;
          dst_ptr <= cfg_wdata[1] ? fbase_q : mbase_q;
          rem_q   <= len_q;
          state   <= S_RD;
        end
        S_RD: if (src_ready) state <= S_WAIT;
        S_WAIT: if (src_rvalid) begin
          buf_q <= src_rdata;
          state <= S_WR;
        end
        S_WR: if (dst_ready) begin
          src_ptr <= src_ptr + AW'(4);
          dst_ptr <= dst_ptr + AW'(4);
          if (!start_q) begin
            state <= S_IDLE;
          end else if (rem_q == '0) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            rem_q <= rem_q - 1'b1;
            state <= S_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module flash_dma_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          irq,
  input logic          fl_valid,
  input logic          fl_we,
  input logic [AW-1:0] fl_addr,
  input logic          fl_ready,
  input logic          mem_valid,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ready
);
  a_r10_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_valid && mem_valid));

  a_r10_fl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid && !fl_ready |=> fl_valid && $stable(fl_addr) && $stable(fl_we));

  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));

  a_r5_fl_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid |-> fl_addr[1:0] == 2'b00);

  a_r5_mem_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);

  a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cfg_we || (fl_valid && fl_ready && fl_we) ||
                         (mem_valid && mem_ready && mem_we)));
endmodule

bind flash_dma_engine flash_dma_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .irq(irq),
  .fl_valid(fl_valid), .fl_we(fl_we), .fl_addr(fl_addr), .fl_ready(fl_ready),
  .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ready(mem_ready)
);

// File: tb/flash_dma_engine_tb_top.sv
module flash_dma_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq;
  logic        fl_valid, fl_we, fl_ready, fl_rvalid;
  logic [31:0] fl_addr, fl_wdata, fl_rdata;
  logic        mem_valid, mem_we, mem_ready, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  flash_dma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .fl_valid(fl_valid), .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_ready(fl_ready), .fl_rvalid(fl_rvalid), .fl_rdata(fl_rdata),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  logic [31:0] fmem [64];
  logic [31:0] smem [64];
  logic stall = 1'b0;
  logic tick = 1'b0;
  int   wr_cnt = 0;
  int   n_chk = 0;
  int   n_bad = 0;

  assign fl_ready  = !stall || tick;
  assign mem_ready = !stall || !tick;

  always @(posedge clk) begin
    tick <= ~tick;
    fl_rvalid  <= 1'b0;
    mem_rvalid <= 1'b0;
    if (fl_valid && fl_ready) begin
      if (fl_we) begin
        fmem[fl_addr[7:2]] <= fl_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        fl_rvalid <= 1'b1;
        fl_rdata  <= fmem[fl_addr[7:2]];
      end
    end
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        smem[mem_addr[7:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= smem[mem_addr[7:2]];
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic setup_run(input logic [31:0] fb, input logic [31:0] mb,
                           input logic [31:0] lf, input logic ie, input logic dir);
    cfg_write(8'h80, 32'h0);
    cfg_write(8'h84, fb);
    cfg_write(8'h88, mb);
    cfg_write(8'h8C, lf);
    cfg_write(8'h08, {28'h0, ie, 3'b000});
    cfg_write(8'h80, {30'h0, dir, 1'b1});
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] v;
    int k;
    k = 0;
    cfg_read(8'h08, v);
    while (!v[11] && k < 2000) begin
      @(negedge clk);
      cfg_read(8'h08, v);
      k++;
    end
    check(tag, {31'h0, v[11]}, 32'h1);
    @(negedge clk);
  endtask

  task automatic clear_all();
    cfg_write(8'h08, 32'h0);
    cfg_write(8'h80, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    cfg_read(8'h08, v); check("R12 status", v, 32'h0);
    cfg_read(8'h80, v); check("R12 ctrl", v, 32'h0);
    cfg_read(8'h84, v); check("R12 fbase", v, 32'h0);
    cfg_read(8'h8C, v); check("R12 len", v, 32'h0);
    check("R12 irq", {31'h0, irq}, 32'h0);
    check("R12 no request", {30'h0, fl_valid, mem_valid}, 32'h0);
  endtask

  task automatic t_flash_to_mem();
    logic [31:0] v;
    int b;
    for (int i = 0; i < 4; i++) begin
      fmem[4+i] = 32'hA500_0000 + i;
      smem[16+i] = 32'h0;
    end
    smem[20] = 32'h5555_5555;
    b = wr_cnt;
    setup_run(32'h10, 32'h40, 32'd12, 1'b1, 1'b0);
    wait_done("R2 done f2m");
    for (int i = 0; i < 4; i++) check("R2 word f2m", smem[16+i], 32'hA500_0000 + i);
    check("R2 no extra word", smem[20], 32'h5555_5555);
    check("R2 word count", wr_cnt - b, 32'd4);
    cfg_read(8'h08, v); check("R1 status layout", v, 32'h0000_0808);
    cfg_read(8'h80, v); check("R1 ctrl layout", v, 32'h1);
    check("R6 irq high", {31'h0, irq}, 32'h1);
    clear_all();
    check("R6 irq cleared", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_mem_to_flash_one();
    int b;
    stall = 1'b1;
    smem[20] = 32'hCAFE_0001;
    smem[21] = 32'hCAFE_0002;
    fmem[32] = 32'h0;
    fmem[33] = 32'h0;
    b = wr_cnt;
    setup_run(32'h83, 32'h50, 32'h0, 1'b1, 1'b1);
    wait_done("R3 done m2f");
    check("R3 word m2f", fmem[32], 32'hCAFE_0001);
    check("R4 single word", fmem[33], 32'h0);
    check("R4 count", wr_cnt - b, 32'd1);
    clear_all();
    stall = 1'b0;
  endtask

  task automatic t_masking();
    logic [31:0] v;
    cfg_write(8'h84, 32'h0000_1237);
    cfg_read(8'h84, v); check("R5 fbase mask", v, 32'h0000_1234);
    cfg_write(8'h88, 32'hFFFF_FFFF);
    cfg_read(8'h88, v); check("R5 mbase mask", v, 32'hFFFF_FFFC);
    cfg_write(8'h8C, 32'hFFFF_FFFF);
    cfg_read(8'h8C, v); check("R5 len mask", v, 32'h01FF_FFFC);
  endtask

  task automatic t_irq_and_launch();
    logic [31:0] v;
    int b;
    fmem[0] = 32'h1111_2222;
    setup_run(32'h0, 32'h80, 32'h0, 1'b0, 1'b0);
    wait_done("R6 done ie off");
    check("R6 irq masked", {31'h0, irq}, 32'h0);
    cfg_write(8'h08, 32'h0000_0808);
    check("R6 irq after enable", {31'h0, irq}, 32'h1);
    cfg_write(8'h08, 32'h0000_0008);
    cfg_read(8'h08, v); check("R7 done cleared", v, 32'h0000_0008);
    b = wr_cnt;
    cfg_write(8'h80, 32'h1);
    repeat (30) @(negedge clk);
    check("R7 no relaunch", wr_cnt - b, 32'd0);
    cfg_read(8'h08, v); check("R7 still not done", v, 32'h0000_0008);
    clear_all();
  endtask

  task automatic t_progress();
    logic [31:0] v;
    int b;
    for (int i = 0; i < 7; i++) fmem[8+i] = 32'hB000_0000 + i;
    b = wr_cnt;
    setup_run(32'h20, 32'h60, 32'd24, 1'b1, 1'b0);
    while (wr_cnt - b < 2) @(negedge clk);
    cfg_read(8'h8C, v); check("R8 remaining", v, 32'd16);
    wait_done("R8 done");
    cfg_read(8'h8C, v); check("R8 idle length", v, 32'd24);
    for (int i = 0; i < 7; i++) check("R2 word 7-run", smem[24+i], 32'hB000_0000 + i);
    clear_all();
  endtask

  task automatic t_abort();
    logic [31:0] v;
    int b;
    for (int i = 0; i < 16; i++) begin
      fmem[16+i] = 32'hC000_0000 + i;
      smem[32+i] = 32'hDEAD_0000;
    end
    b = wr_cnt;
    setup_run(32'h40, 32'h80, 32'd60, 1'b1, 1'b0);
    while (wr_cnt - b < 3) @(negedge clk);
    cfg_write(8'h80, 32'h0);
    repeat (40) @(negedge clk);
    check("R9 words moved", wr_cnt - b, 32'd4);
    check("R9 current word finished", smem[35], 32'hC000_0003);
    check("R9 next word untouched", smem[36], 32'hDEAD_0000);
    cfg_read(8'h08, v); check("R9 done clear", v, 32'h0000_0008);
    check("R9 irq low", {31'h0, irq}, 32'h0);
    clear_all();
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    stall = 1'b1;
    for (int i = 0; i < 4; i++) smem[40+i] = 32'hD000_0000 + i;
    setup_run(32'hC0, 32'hA0, 32'd12, 1'b1, 1'b1);
    cfg_write(8'h84, 32'h0);
    cfg_write(8'h8C, 32'h0);
    wait_done("R11 done");
    cfg_read(8'h84, v); check("R11 fbase kept", v, 32'h0000_00C0);
    cfg_read(8'h8C, v); check("R11 len kept", v, 32'd12);
    for (int i = 0; i < 4; i++) check("R11 data intact", fmem[48+i], 32'hD000_0000 + i);
    clear_all();
    stall = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      fmem[i] = 32'h0;
      smem[i] = 32'h0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flash_to_mem();
    t_mem_to_flash_one();
    t_masking();
    t_irq_and_launch();
    t_progress();
    t_abort();
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R12 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule